// File: doc/BRIEF.md
# Fetch Command Requester

This block is the requesting side of a byte-wide fetch link. A local client hands it a fetch request made of a 32-bit start address and a 16-bit byte count. The block turns the request into a six-byte command on an outgoing push channel, then pulls exactly the requested number of bytes from an incoming pop channel and forwards them on a valid/ready stream. The far side reports a full flag for the outgoing channel and an empty flag for the incoming one. It may raise either flag only in reply to a push or pop from this block. The block can therefore trust a flag it sampled earlier, and it can push or pop on back-to-back cycles.

After reset the block brings the link to a known state. It pops and discards whatever the far side still holds. Once the incoming channel reports empty, it issues two more pops on the empty channel, and the far side treats these as a link reset. The block assumes this reset also clears the outgoing channel, so it never waits for that side to drain. Only after this sequence does it accept requests.

Top module: `fetch_requester`

## Requirements
- R1: While `rst` is high no pop strobe is issued. After reset, `req_ready` stays low while every byte present on the incoming channel is popped and discarded, and none of them appears on the response stream.
- R2: Once the incoming channel reads empty during start-up, exactly two pops are issued while it is empty. After that, start-up pops stop and no push is made before the first request.
- R3: Start-up finishes and `req_ready` rises without regard to `tx_full`, even if `tx_full` stays high throughout.
- R4: `tx_wr` is high only in cycles where `tx_full` is low. While `tx_full` is high, the pending command byte is held. While it is low, command bytes are pushed on consecutive cycles.
- R5: The command bytes go out in this order: `req_addr[31:24]`, `req_addr[23:16]`, `req_addr[15:8]`, `req_addr[7:0]`, `req_len[15:8]`, `req_len[7:0]`.
- R6: A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only when start-up is finished and `busy` is low. `busy` is high from the cycle after acceptance until the cycle after the last response byte is transferred, so a request of N bytes with no stalls keeps `busy` high for 6+N cycles.
- R7: After a command, exactly `req_len` bytes are popped. Any further bytes stay in the incoming channel, unpopped.
- R8: During the response phase, `rsp_valid` equals the inverse of `rx_empty` and `rsp_data` equals `rx_data` in the same cycle. A pop happens only on a response transfer, so a low `rsp_ready` pauses popping.
- R9: A request with `req_len` of 0 pushes the six command bytes, pops nothing, and drops `busy` in the cycle after the sixth push, giving 6 busy cycles.
- R10: No response pop occurs before the sixth command byte is pushed. With data waiting, the first pop follows in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 32 | Start address of the fetch |
| req_len | input | 16 | Number of bytes to fetch |
| busy | output | 1 | A command or its response is in progress |
| tx_full | input | 1 | Outgoing channel cannot take a byte |
| tx_data | output | 8 | Command byte being pushed |
| tx_wr | output | 1 | Push strobe, one byte per cycle |
| rx_empty | input | 1 | Incoming channel has no byte |
| rx_data | input | 8 | Byte at the head of the incoming channel |
| rx_rd | output | 1 | Pop strobe, one byte per cycle |
| rsp_valid | output | 1 | Response byte available |
| rsp_ready | input | 1 | Consumer takes the response byte |
| rsp_data | output | 8 | Response byte |

## Verification
Start-up is exercised with stale bytes waiting and `tx_full` stuck high. This separates a correct purge-plus-two-pops sequence from one that pops too few times, pops too many, or waits on the outgoing side. Requests run with a free link, with `tx_full` raised across the command, and with `rsp_ready` held low. The first case fixes the byte order and the exact busy length. The second shows that a push is held rather than lost. The third shows that popping follows the consumer and not the data. Zero-length requests, and responses with one spare byte left behind, mark the count boundary on both sides.

// File: rtl/fetch_req_pkg.sv
package fetch_req_pkg;

    parameter int ADDR_W      = 32;
    parameter int LEN_W       = 16;
    parameter int BYTE_W      = 8;
    parameter int RESET_READS = 2;

    localparam int CMD_BITS  = ADDR_W + LEN_W;
    localparam int CMD_BYTES = CMD_BITS / BYTE_W;
    localparam int IDX_W     = $clog2(CMD_BYTES);
    localparam int RCNT_W    = (RESET_READS > 1) ? $clog2(RESET_READS) : 1;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } fetch_req_t;

    typedef enum logic [1:0] {
        LNK_HOLD,
        LNK_PURGE,
        LNK_RESET,
        LNK_READY
    } link_state_t;

    // Byte idx of the command, most significant address byte first,
    // length bytes last.
    function automatic byte_t cmd_byte(input fetch_req_t r, input logic [IDX_W-1:0] idx);
        logic [CMD_BITS-1:0] word;
        logic [CMD_BITS-1:0] shifted;
        int unsigned         sh;
        word    = {r.addr, r.len};
        sh      = (CMD_BYTES - 1 - int'(idx)) * BYTE_W;
        shifted = word >> sh;
        return shifted[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/freq_link_init.sv
module freq_link_init
    import fetch_req_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_empty,
    output logic rd_o,
    output logic done_o
);

    link_state_t           state_q;
    logic [RCNT_W-1:0]     cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LNK_HOLD;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                LNK_HOLD:  state_q <= LNK_PURGE;
                LNK_PURGE: if (rx_empty) state_q <= LNK_RESET;
                LNK_RESET: begin
                    if (cnt_q == RCNT_W'(RESET_READS - 1)) state_q <= LNK_READY;
                    else cnt_q <= cnt_q + 1'b1;
                end
                default:   state_q <= LNK_READY;
            endcase
        end
    end

    // Pops on the purge use the look-ahead empty flag directly; the
    // reset pops are issued on an empty channel by intent.
    always_comb begin
        rd_o = 1'b0;
        if (state_q == LNK_PURGE && !rx_empty) rd_o = 1'b1;
        if (state_q == LNK_RESET)              rd_o = 1'b1;
    end

    assign done_o = (state_q == LNK_READY);

endmodule

// File: rtl/freq_cmd_ser.sv
module freq_cmd_ser
    import fetch_req_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  fetch_req_t           req,
    input  logic                 tx_full,
    output byte_t                tx_data,
    output logic                 tx_wr,
    output logic                 active_o,
    output logic                 done_o,
    output logic [LEN_W-1:0]     len_o
);

    logic                active_q;
    logic [IDX_W-1:0]    idx_q;
    fetch_req_t          req_q;
    logic                last;

    assign tx_wr   = active_q && !tx_full;
    assign tx_data = cmd_byte(req_q, idx_q);
    assign last    = (idx_q == IDX_W'(CMD_BYTES - 1));
    assign done_o  = tx_wr && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            req_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            req_q    <= req;
        end else if (tx_wr) begin
            if (last) active_q <= 1'b0;
            else      idx_q    <= idx_q + 1'b1;
        end
    end

    assign active_o = active_q;
    assign len_o    = req_q.len;

endmodule

// File: rtl/freq_rsp_col.sv
module freq_rsp_col
    import fetch_req_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    input  logic              rx_empty,
    input  byte_t             rx_data,
    output logic              rd_o,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output byte_t             rsp_data,
    output logic              active_o
);

    logic              active_q;
    logic [LEN_W-1:0]  remain_q;

    assign rsp_valid = active_q && !rx_empty;
    assign rsp_data  = rx_data;
    assign rd_o      = rsp_valid && rsp_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            remain_q <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            remain_q <= len;
        end else if (rd_o) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == LEN_W'(1)) active_q <= 1'b0;
        end
    end

    assign active_o = active_q;

endmodule

// File: rtl/fetch_requester.sv
module fetch_requester
    import fetch_req_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    output logic               busy,
    input  logic               tx_full,
    output logic [BYTE_W-1:0]  tx_data,
    output logic               tx_wr,
    input  logic               rx_empty,
    input  logic [BYTE_W-1:0]  rx_data,
    output logic               rx_rd,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [BYTE_W-1:0]  rsp_data
);

    logic              init_done;
    logic              init_rd;
    logic              rsp_rd;
    logic              cmd_active;
    logic              cmd_done;
    logic              rsp_active;
    logic              accept;
    logic              rsp_start;
    logic [LEN_W-1:0]  cmd_len;
    fetch_req_t        req_in;

    assign req_in    = '{addr: req_addr, len: req_len};
    assign busy      = cmd_active || rsp_active;
    assign req_ready = init_done && !busy;
    assign accept    = req_valid && req_ready;
    assign rsp_start = cmd_done && (cmd_len != '0);
    assign rx_rd     = init_rd || rsp_rd;

    freq_link_init u_init (
        .clk      (clk),
        .rst      (rst),
        .rx_empty (rx_empty),
        .rd_o     (init_rd),
        .done_o   (init_done)
    );

    freq_cmd_ser u_cmd (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .req      (req_in),
        .tx_full  (tx_full),
        .tx_data  (tx_data),
        .tx_wr    (tx_wr),
        .active_o (cmd_active),
        .done_o   (cmd_done),
        .len_o    (cmd_len)
    );

    freq_rsp_col u_rsp (
        .clk       (clk),
        .rst       (rst),
        .start     (rsp_start),
        .len       (cmd_len),
        .rx_empty  (rx_empty),
        .rx_data   (rx_data),
        .rd_o      (rsp_rd),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data),
        .active_o  (rsp_active)
    );

endmodule

// File: rtl/fetch_requester_chk.sv
module fetch_requester_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic busy,
    input logic tx_full,
    input logic tx_wr,
    input logic rx_empty,
    input logic rx_rd,
    input logic rsp_valid,
    input logic rsp_ready,
    input logic init_done
);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        tx_wr |-> !tx_full);

    p_push_after_init_r2: assert property (@(posedge clk) disable iff (rst)
        tx_wr |-> (busy && init_done));

    p_pop_guard_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && busy) |-> (!rx_empty && rsp_ready));

    p_valid_has_data_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !rx_empty);

    p_xfer_pops_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready) |-> rx_rd);

    p_ready_idle_r6: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!busy && init_done));

    p_accept_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);

    p_init_silent_r1: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !rsp_valid);

    p_init_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

endmodule

bind fetch_requester fetch_requester_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .tx_full   (tx_full),
    .tx_wr     (tx_wr),
    .rx_empty  (rx_empty),
    .rx_rd     (rx_rd),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .init_done (init_done)
);

// File: tb/sim_fetch_requester.sv
module sim_fetch_requester;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [15:0] req_len;
    logic        busy;
    logic        tx_full;
    logic [7:0]  tx_data;
    logic        tx_wr;
    logic        rx_empty;
    logic [7:0]  rx_data;
    logic        rx_rd;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [7:0]  rsp_data;

    always #4 clk = ~clk;

    fetch_requester u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .busy(busy),
        .tx_full(tx_full), .tx_data(tx_data), .tx_wr(tx_wr),
        .rx_empty(rx_empty), .rx_data(rx_data), .rx_rd(rx_rd),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
    );

    // Peripheral model: incoming queue, outgoing log, response log.
    logic [7:0]  rxq    [0:255];
    logic [7:0]  txlog  [0:255];
    logic [7:0]  rsplog [0:255];
    int unsigned rx_head = 0, rx_tail = 0;
    int unsigned tx_n = 0, tx_ovf = 0, rsp_n = 0;
    int unsigned rd_total = 0, rd_empty = 0, rd_in_rst = 0;
    int unsigned busy_cyc = 0, cyc = 0;
    int unsigned last_tx_cyc = 0, first_rd_cyc = 0;
    bit          rd_seen = 0;
    int          n_chk = 0, n_err = 0;

    assign rx_empty = (rx_head == rx_tail);
    assign rx_data  = rxq[rx_head % 256];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rx_rd) begin
            rd_total <= rd_total + 1;
            if (rst) rd_in_rst <= rd_in_rst + 1;
            if (rx_head == rx_tail) rd_empty <= rd_empty + 1;
            else rx_head <= rx_head + 1;
            if (busy && !rd_seen) begin
                rd_seen      <= 1'b1;
                first_rd_cyc <= cyc;
            end
        end
        if (tx_wr) begin
            txlog[tx_n % 256] <= tx_data;
            tx_n        <= tx_n + 1;
            last_tx_cyc <= cyc;
            if (tx_full) tx_ovf <= tx_ovf + 1;
        end
        if (rsp_valid && rsp_ready) begin
            rsplog[rsp_n % 256] <= rsp_data;
            rsp_n <= rsp_n + 1;
        end
        if (busy) busy_cyc <= busy_cyc + 1;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic push_rx(input logic [7:0] b);
        rxq[rx_tail % 256] = b;
        rx_tail++;
    endtask

    task automatic discard_rx();
        rx_tail = rx_head;
    endtask

    task automatic issue(input logic [31:0] a, input logic [15:0] l);
        @(negedge clk);
        req_addr  = a;
        req_len   = l;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic check_cmd(input string tag, input int unsigned base,
                             input logic [31:0] a, input logic [15:0] l);
        logic [47:0] w;
        w = {a, l};
        for (int i = 0; i < 6; i++)
            chk(tag, txlog[(base + i) % 256], w[47 - 8*i -: 8]);
    endtask

    task automatic t_startup();
        rst = 1'b1; tx_full = 1'b1; req_valid = 1'b0; rsp_ready = 1'b1;
        req_addr = '0; req_len = '0;
        push_rx(8'h5A); push_rx(8'h6B); push_rx(8'h7C);
        repeat (4) @(negedge clk);
        chk("R1 no pop in reset", rd_in_rst, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 req_ready low after reset", req_ready, 0);
        repeat (12) @(negedge clk);
        chk("R1 stale bytes purged", rx_tail - rx_head, 0);
        chk("R1 nothing forwarded", rsp_n, 0);
        chk("R2 two pops on empty", rd_empty, 2);
        chk("R2 total start-up pops", rd_total, 5);
        chk("R2 no push during start-up", tx_n, 0);
        chk("R3 ready despite tx_full", req_ready, 1);
        push_rx(8'h99);
        repeat (4) @(negedge clk);
        chk("R2 pops stop after start-up", rd_total, 5);
        discard_rx();
        tx_full = 1'b0;
    endtask

    task automatic t_basic();
        int unsigned tx0, rsp0, rd0;
        tx0 = tx_n; rsp0 = rsp_n; rd0 = rd_total; rd_seen = 0;
        push_rx(8'h11); push_rx(8'h22); push_rx(8'h33); push_rx(8'h44);
        issue(32'hA1B2C3D4, 16'd3);
        chk("R6 busy after accept", busy, 1);
        chk("R6 ready low while busy", req_ready, 0);
        wait_idle();
        chk("R5 six bytes pushed", tx_n - tx0, 6);
        check_cmd("R5 command byte", tx0, 32'hA1B2C3D4, 16'd3);
        chk("R7 pops equal length", rd_total - rd0, 3);
        chk("R7 spare byte left", rx_tail - rx_head, 1);
        chk("R8 resp byte 0", rsplog[rsp0 % 256], 8'h11);
        chk("R8 resp byte 2", rsplog[(rsp0 + 2) % 256], 8'h33);
        chk("R10 first pop right after last push", first_rd_cyc, last_tx_cyc + 1);
        chk("R6 ready back when idle", req_ready, 1);
        discard_rx();
    endtask

    task automatic t_stall();
        int unsigned tx0, rsp0, rd0;
        tx0 = tx_n; rsp0 = rsp_n; rd0 = rd_total;
        tx_full = 1'b1; rsp_ready = 1'b0;
        push_rx(8'hC1); push_rx(8'hC2);
        issue(32'h01020304, 16'd2);
        repeat (5) @(negedge clk);
        chk("R4 no push while full", tx_n - tx0, 0);
        chk("R10 no pop before command", rd_total - rd0, 0);
        tx_full = 1'b0;
        repeat (8) @(negedge clk);
        chk("R4 command completes", tx_n - tx0, 6);
        chk("R8 rsp_valid with data", rsp_valid, 1);
        chk("R8 rsp_data follows head", rsp_data, 8'hC1);
        chk("R8 no pop while not ready", rd_total - rd0, 0);
        rsp_ready = 1'b1;
        wait_idle();
        chk("R4 overflow count", tx_ovf, 0);
        check_cmd("R5 stalled command byte", tx0, 32'h01020304, 16'd2);
        chk("R8 stalled resp byte 1", rsplog[(rsp0 + 1) % 256], 8'hC2);
        chk("R7 stalled pops", rd_total - rd0, 2);
    endtask

    task automatic t_zero();
        int unsigned tx0, rd0, b0;
        tx0 = tx_n; rd0 = rd_total; b0 = busy_cyc;
        push_rx(8'hE1); push_rx(8'hE2);
        issue(32'hDEADBEEF, 16'd0);
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R9 six pushes", tx_n - tx0, 6);
        check_cmd("R9 zero command byte", tx0, 32'hDEADBEEF, 16'd0);
        chk("R9 no pops", rd_total - rd0, 0);
        chk("R9 busy cycles", busy_cyc - b0, 6);
        discard_rx();
    endtask

    task automatic t_burst();
        int unsigned rsp0, b0;
        rsp0 = rsp_n; b0 = busy_cyc; rd_seen = 0;
        for (int i = 0; i < 5; i++) push_rx(8'(8'h80 + i));
        issue(32'h00000010, 16'd5);
        wait_idle();
        chk("R6 busy length 6+N", busy_cyc - b0, 11);
        chk("R7 all consumed", rx_tail - rx_head, 0);
        chk("R8 burst count", rsp_n - rsp0, 5);
        chk("R8 burst last byte", rsplog[(rsp0 + 4) % 256], 8'h84);
        chk("R10 burst first pop", first_rd_cyc, last_tx_cyc + 1);
    endtask

    initial begin
        t_startup();
        t_basic();
        t_stall();
        t_zero();
        t_burst();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule